// File: doc/BRIEF.md
# Programmable Pixel Clock Divider with Dual-Mode Output Pin

This block derives a pixel clock from the master clock by dividing it by a programmable integer ratio. It also launches pixel data, a horizontal sync and a read-out strobe in step with that pixel clock. A single output pin serves one of two purposes. In clock mode the pin forwards the divided pixel clock, and a select bit chooses whether the outputs change on its rising or its falling edge. In data-valid mode the pin carries a one-master-cycle strobe for each active pixel instead. This strobe is aligned to the master clock, so a receiver can capture the data with the master clock or a clock derived from it.

After a power-down ends, the block keeps its ready flag low for a programmable number of pixel clock periods. The wait is counted in divided pixel periods, not in master cycles. Software sets the ratio, the edge, the mode and the wait length through a byte-wide register port with a combinational read.

Top module: `pxd_pin_ctrl`

## Requirements
- R1: After reset, the control register (address 3Fh) reads 01h and the wait-count register (address 3Dh) reads 7Dh. Reading any other address returns 00h. A write to any other address changes neither register.
- R2: Control bits 4:0 hold the divide ratio N, and a value of 0 acts as 1. For N of 2 or more, the pixel clock has a period of N master cycles. In each period it is high for the first ceil(N/2) cycles after the edge on which it rises, then low for the rest.
- R3: With N = 1, the pin in clock mode follows the master clock. A write that sets control bit 6 (data-valid mode) together with N = 1 stores bit 6 as 0.
- R4: A write that changes the effective ratio restarts the divider on that edge: the pin rises, and the new ratio's high phase begins.
- R5: In clock mode, pixel data, sync and read-out outputs take the values present at the master edge where the pin rises (control bit 5 = 0) or falls (bit 5 = 1). With N = 1, they update on every edge.
- R6: When control bit 6 is 1, the pin is high for exactly one master cycle per pixel period. This happens only when the active-pixel input was high at the launching edge and the power-up wait has ended. Outputs then launch at the pixel period start, whatever bit 5 holds.
- R7: While power-down is high, the ready flag and the pin are low, the divider is parked one cycle before a period start, and the wait reloads from register 3Dh.
- R8: After power-down is released, or after reset, ready rises at the edge that starts the K-th pixel period, where K is the wait count. With K = 0, ready rises at the first edge.
- R9: Bit 7 of the control register is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_i | input | 1 | Power-down request |
| act_pix_i | input | 1 | High while the current pixel is active (not blanking) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| pix_i | input | DATA_W | Pixel data to launch |
| hsync_i | input | 1 | Horizontal sync to launch |
| rdstb_i | input | 1 | Read-out strobe to launch |
| pix_o | output | DATA_W | Launched pixel data |
| hsync_o | output | 1 | Launched horizontal sync |
| rdstb_o | output | 1 | Launched read-out strobe |
| clk_pin_o | output | 1 | Pixel clock or data-valid strobe, per mode |
| ready_o | output | 1 | Power-up wait complete |

## Verification
Several properties are checked on every cycle:
- Power-down forces both ready and the pin low.
- The divider phase never reaches the ratio.
- Launched data changes only on a launch event.
- Ready rises only on a pixel period start.
- A data-valid strobe always follows a period start with the active-pixel input high.

The exact phase of the high and low halves, the count of periods before ready rises, and the one-strobe-per-period rate come from the bench's behavioural model, compared every clock. The restart on a ratio change, the forced-off mode bit at N = 1, and the ignored rising-versus-falling choice in data-valid mode are also shown only by the bench.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
  // Width of the byte-wide register port.
  localparam int BYTE_W   = 8;
  // Divide ratio field occupies the low bits of the control register.
  localparam int RATIO_W  = 5;
  // Control bit that selects the falling launch edge.
  localparam int EDGE_BIT = 5;
  // Control bit that switches the pin to the data-valid strobe.
  localparam int VD_BIT   = 6;
  // Reserved control bit, always read as zero.
  localparam int RSV_BIT  = 7;

  typedef logic [RATIO_W-1:0] ratio_t;

  // A programmed ratio of zero behaves as one.
  function automatic ratio_t eff_ratio(input ratio_t raw);
    return (raw == '0) ? ratio_t'(1) : raw;
  endfunction

  // Number of master cycles the pixel clock stays high: ceil(n/2).
  function automatic ratio_t high_len(input ratio_t n);
    logic [RATIO_W:0] wide;
    wide = {1'b0, n} + (RATIO_W+1)'(1);
    return wide[RATIO_W:1];
  endfunction

  function automatic logic is_unity(input ratio_t n);
    return n == ratio_t'(1);
  endfunction
endpackage

// File: rtl/pxd_regs.sv
module pxd_regs
  import pxd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PU_ADDR   = 8'h3D,
  parameter logic [BYTE_W-1:0] CTRL_ADDR = 8'h3F,
  parameter logic [BYTE_W-1:0] CTRL_RST  = 8'h01,
  parameter logic [BYTE_W-1:0] PU_RST    = 8'h7D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output ratio_t            ratio_cur,
  output ratio_t            ratio_next,
  output logic              restart,
  output logic              edge_fall,
  output logic              vd_mode,
  output logic [BYTE_W-1:0] pu_count
);
  localparam logic [BYTE_W-1:0] RSV_MASK = ~(BYTE_W'(1) << RSV_BIT);

  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] pu_q;
  logic              wr_ctrl, wr_pu;
  ratio_t            wr_ratio;

  assign wr_ctrl  = we && (addr == CTRL_ADDR);
  assign wr_pu    = we && (addr == PU_ADDR);
  assign wr_ratio = eff_ratio(wdata[RATIO_W-1:0]);

  assign ratio_cur  = eff_ratio(ctrl_q[RATIO_W-1:0]);
  assign restart    = wr_ctrl && (wr_ratio != ratio_cur);
  assign ratio_next = restart ? wr_ratio : ratio_cur;

  // Stored control byte: reserved bit dropped, valid mode refused at unity ratio.
  always_comb begin
    ctrl_d = wdata & RSV_MASK;
    if (is_unity(wr_ratio)) begin
      ctrl_d[VD_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST & RSV_MASK;
      pu_q   <= PU_RST;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_d;
      end
      if (wr_pu) begin
        pu_q <= wdata;
      end
    end
  end

  assign edge_fall = ctrl_q[EDGE_BIT];
  assign vd_mode   = ctrl_q[VD_BIT];
  assign pu_count  = pu_q;

  always_comb begin
    if (addr == PU_ADDR) begin
      rdata = pu_q;
    end else if (addr == CTRL_ADDR) begin
      rdata = ctrl_q;
    end else begin
      rdata = '0;
    end
  end
endmodule

// File: rtl/pxd_divider.sv
module pxd_divider
  import pxd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pd,
  input  logic   restart,
  input  ratio_t ratio_cur,
  input  ratio_t ratio_next,
  output ratio_t phase,
  output logic   pclk,
  output logic   rise_ev,
  output logic   fall_ev
);
  ratio_t ph_q, ph_d;
  logic   pclk_q, pclk_d;
  logic   wrap;

  assign wrap = (ph_q >= (ratio_cur - ratio_t'(1)));

  always_comb begin
    rise_ev = 1'b0;
    if (pd) begin
      // Parked one cycle before a period start.
      ph_d = ratio_next - ratio_t'(1);
    end else if (restart || wrap) begin
      ph_d    = '0;
      rise_ev = 1'b1;
    end else begin
      ph_d = ph_q + ratio_t'(1);
    end
    pclk_d  = !pd && (ph_d < high_len(ratio_next));
    fall_ev = !pd && pclk_q && !pclk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      pclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pclk_q <= pclk_d;
    end
  end

  assign phase = ph_q;
  assign pclk  = pclk_q;
endmodule

// File: rtl/pxd_powerup.sv
module pxd_powerup #(
  parameter int               CNT_W     = 8,
  parameter logic [CNT_W-1:0] RST_COUNT = 8'h7D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             ready,
  output logic             done_next
);
  logic [CNT_W-1:0] wait_q, wait_d;
  logic             ready_q;

  always_comb begin
    if (pd) begin
      wait_d = load_val;
    end else if (tick && (wait_q != '0)) begin
      wait_d = wait_q - CNT_W'(1);
    end else begin
      wait_d = wait_q;
    end
    done_next = !pd && (wait_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= RST_COUNT;
      ready_q <= 1'b0;
    end else begin
      wait_q  <= wait_d;
      ready_q <= done_next;
    end
  end

  assign ready = ready_q;
endmodule

// File: rtl/pxd_launch.sv
module pxd_launch #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              strobe_set,
  input  logic [DATA_W-1:0] pix_in,
  input  logic              hs_in,
  input  logic              rd_in,
  output logic [DATA_W-1:0] pix_q,
  output logic              hs_q,
  output logic              rd_q,
  output logic              strobe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q    <= '0;
      hs_q     <= 1'b0;
      rd_q     <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe_set;
      if (launch) begin
        pix_q <= pix_in;
        hs_q  <= hs_in;
        rd_q  <= rd_in;
      end
    end
  end
endmodule

// File: rtl/pxd_pin_ctrl.sv
module pxd_pin_ctrl
  import pxd_pkg::*;
#(
  parameter int                DATA_W    = 10,
  parameter logic [BYTE_W-1:0] PU_ADDR   = 8'h3D,
  parameter logic [BYTE_W-1:0] CTRL_ADDR = 8'h3F,
  parameter logic [BYTE_W-1:0] CTRL_RST  = 8'h01,
  parameter logic [BYTE_W-1:0] PU_RST    = 8'h7D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_i,
  input  logic              act_pix_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [DATA_W-1:0] pix_i,
  input  logic              hsync_i,
  input  logic              rdstb_i,
  output logic [DATA_W-1:0] pix_o,
  output logic              hsync_o,
  output logic              rdstb_o,
  output logic              clk_pin_o,
  output logic              ready_o
);
  // Named internal events, also observed by the bound checker.
  ratio_t            ratio_cur, ratio_next, phase;
  logic              restart, edge_fall, vd_mode;
  logic [BYTE_W-1:0] pu_count;
  logic              pclk, rise_ev, fall_ev;
  logic              wait_done_next;
  logic              launch_ev, strobe_set, strobe_q;

  pxd_regs #(
    .PU_ADDR  (PU_ADDR),
    .CTRL_ADDR(CTRL_ADDR),
    .CTRL_RST (CTRL_RST),
    .PU_RST   (PU_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we_i),
    .addr      (reg_addr_i),
    .wdata     (reg_wdata_i),
    .rdata     (reg_rdata_o),
    .ratio_cur (ratio_cur),
    .ratio_next(ratio_next),
    .restart   (restart),
    .edge_fall (edge_fall),
    .vd_mode   (vd_mode),
    .pu_count  (pu_count)
  );

  pxd_divider u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd        (pd_i),
    .restart   (restart),
    .ratio_cur (ratio_cur),
    .ratio_next(ratio_next),
    .phase     (phase),
    .pclk      (pclk),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev)
  );

  pxd_powerup #(
    .CNT_W    (BYTE_W),
    .RST_COUNT(PU_RST)
  ) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd       (pd_i),
    .tick     (rise_ev),
    .load_val (pu_count),
    .ready    (ready_o),
    .done_next(wait_done_next)
  );

  // Falling launch only in clock mode with a real division; otherwise period start.
  assign launch_ev  = (vd_mode || !edge_fall || is_unity(ratio_next)) ? rise_ev : fall_ev;
  assign strobe_set = vd_mode && !pd_i && act_pix_i && rise_ev && wait_done_next;

  pxd_launch #(
    .DATA_W(DATA_W)
  ) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch_ev),
    .strobe_set(strobe_set),
    .pix_in    (pix_i),
    .hs_in     (hsync_i),
    .rd_in     (rdstb_i),
    .pix_q     (pix_o),
    .hs_q      (hsync_o),
    .rd_q      (rdstb_o),
    .strobe_q  (strobe_q)
  );

  // Pin select: strobe, forwarded master clock at unity, or divided clock.
  always_comb begin
    if (vd_mode) begin
      clk_pin_o = strobe_q;
    end else if (is_unity(ratio_cur)) begin
      clk_pin_o = pclk & clk;
    end else begin
      clk_pin_o = pclk;
    end
  end
endmodule

// File: rtl/pxd_checker.sv
module pxd_checker
  import pxd_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pd_i,
  input logic              act_pix_i,
  input logic              clk_pin_o,
  input logic              ready_o,
  input logic [DATA_W-1:0] pix_o,
  input logic              vd_mode,
  input logic              rise_ev,
  input logic              launch_ev,
  input ratio_t            phase,
  input ratio_t            ratio_cur
);
  assert_rdy_off_in_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> !ready_o);

  assert_pin_off_in_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> !clk_pin_o);

  assert_strobe_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_mode && clk_pin_o) |-> ($past(act_pix_i) && $past(rise_ev)));

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase < ratio_cur);

  assert_ready_on_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(rise_ev));

  assert_data_on_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pix_o) |-> $past(launch_ev));
endmodule

bind pxd_pin_ctrl pxd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pd_i     (pd_i),
  .act_pix_i(act_pix_i),
  .clk_pin_o(clk_pin_o),
  .ready_o  (ready_o),
  .pix_o    (pix_o),
  .vd_mode  (vd_mode),
  .rise_ev  (rise_ev),
  .launch_ev(launch_ev),
  .phase    (phase),
  .ratio_cur(ratio_cur)
);

// File: tb/pxd_pin_ctrl_bench.sv
module pxd_pin_ctrl_bench;
  localparam int DATA_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pd = 1'b0, act = 1'b0, we = 1'b0;
  logic [7:0]        addr = 8'h00, wdata = 8'h00;
  logic [DATA_W-1:0] pix = '0;
  logic              hs = 1'b0, rd = 1'b0;
  logic [7:0]        rdata;
  logic [DATA_W-1:0] pix_o;
  logic              hs_o, rd_o, pin, ready;

  always #4 clk = ~clk;

  pxd_pin_ctrl #(.DATA_W(DATA_W)) u_pxd_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_i(pd), .act_pix_i(act),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pix_i(pix), .hsync_i(hs), .rdstb_i(rd),
    .pix_o(pix_o), .hsync_o(hs_o), .rdstb_o(rd_o),
    .clk_pin_o(pin), .ready_o(ready)
  );

  int n_cmp = 0, n_bad = 0;

  // Behavioural reference state.
  int m_ctrl = 'h01, m_pu = 'h7D, m_ph = 0, m_wait = 'h7D, m_data = 0;
  bit m_pclk = 0, m_ready = 0, m_strobe = 0, m_hs = 0, m_rd = 0;

  function automatic int eff(input int r);
    return (r == 0) ? 1 : r;
  endfunction

  task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    n_cmp++;
    if (actual !== expected) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, actual, expected);
    end
  endtask

  task automatic model_step();
    int  n_cur, n_new, nr;
    bit  restart, rise, fall, old_pclk, vd, efall, launch;
    n_cur = eff(m_ctrl & 31);
    n_new = n_cur;
    restart = 0;
    if (we && addr == 8'h3F) begin
      nr = eff(wdata & 31);
      if (nr != n_cur) begin restart = 1; n_new = nr; end
    end
    vd = ((m_ctrl >> 6) & 1) != 0;
    efall = ((m_ctrl >> 5) & 1) != 0;
    old_pclk = m_pclk;
    rise = 0;
    if (pd) begin
      m_ph = n_new - 1;
      m_pclk = 0;
    end else begin
      if (restart || m_ph >= n_cur - 1) begin m_ph = 0; rise = 1; end
      else m_ph = m_ph + 1;
      m_pclk = (2 * m_ph < n_new);
    end
    fall = !pd && old_pclk && !m_pclk;
    launch = (vd || !efall || n_new == 1) ? rise : fall;
    if (pd) m_wait = m_pu;
    else if (rise && m_wait > 0) m_wait = m_wait - 1;
    m_ready = !pd && (m_wait == 0);
    m_strobe = vd && !pd && act && rise && (m_wait == 0);
    if (launch) begin m_data = int'(pix); m_hs = hs; m_rd = rd; end
    if (we && addr == 8'h3F) begin
      m_ctrl = wdata & 'h7F;
      if (((wdata >> 6) & 1) != 0 && eff(wdata & 31) == 1) m_ctrl = m_ctrl & ~(1 << 6);
    end
    if (we && addr == 8'h3D) m_pu = wdata;
  endtask

  task automatic compare_all();
    int  exp_rd;
    bit  exp_pin;
    exp_pin = (((m_ctrl >> 6) & 1) != 0) ? m_strobe : m_pclk;
    check((((m_ctrl >> 6) & 1) != 0) ? "R6 pin" : "R2 pin", 32'(pin), 32'(exp_pin));
    check("R5 data", 32'(pix_o), 32'(m_data));
    check("R5 hsync", 32'(hs_o), 32'(m_hs));
    check("R5 readout", 32'(rd_o), 32'(m_rd));
    check(pd ? "R7 ready" : "R8 ready", 32'(ready), 32'(m_ready));
    exp_rd = (addr == 8'h3D) ? m_pu : (addr == 8'h3F) ? (m_ctrl & 'h7F) : 0;
    check("R1 rdata", 32'(rdata), 32'(exp_rd));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    compare_all();
    pix = pix + DATA_W'(3);
    hs = pix[2];
    rd = pix[3];
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] expected);
    addr = a;
    #1;
    check(tag, 32'(rdata), 32'(expected));
  endtask

  initial begin
    int cnt;
    logic [DATA_W-1:0] sent;
    logic prev_pin;
    repeat (3) @(posedge clk);
    #2;
    addr = 8'h3F;
    #1;
    check("R1 reset ctrl", 32'(rdata), 32'h01);
    check("R7 reset pin", 32'(pin), 32'h0);
    check("R8 reset ready", 32'(ready), 32'h0);
    rst_n = 1'b1;
    rd_chk("R1 reset count", 8'h3D, 8'h7D);

    // R8: start-up wait of 125 periods at unity ratio.
    repeat (124) tick();
    check("R8 not yet ready", 32'(ready), 32'h0);
    tick();
    check("R8 ready after 125", 32'(ready), 32'h1);

    // R4 / R2: ratio 4, restart and duty pattern.
    wr(8'h3F, 8'h04);
    check("R4 restart high", 32'(pin), 32'h1);
    tick(); check("R2 high half", 32'(pin), 32'h1);
    tick(); check("R2 low half", 32'(pin), 32'h0);
    tick(); tick(); check("R2 next period", 32'(pin), 32'h1);
    repeat (20) tick();

    // R5: falling launch edge.
    wr(8'h3F, 8'h24);
    for (int i = 0; i < 16; i++) begin
      sent = pix; prev_pin = pin;
      tick();
      if (prev_pin && !pin) check("R5 launch on fall", 32'(pix_o), 32'(sent));
    end

    // R2: odd ratio, then ratio 0 acting as 1.
    wr(8'h3F, 8'h05);
    repeat (15) tick();
    wr(8'h3F, 8'h00);
    @(negedge clk); #1;
    check("R2 ratio0 pin low phase", 32'(pin), 32'h0);
    tick();
    check("R2 ratio0 pin high phase", 32'(pin), 32'h1);
    repeat (5) tick();

    // R3: valid mode refused at unity ratio.
    wr(8'h3F, 8'h41);
    rd_chk("R3 mode bit cleared", 8'h3F, 8'h01);
    @(negedge clk); #1;
    check("R3 pin follows clk low", 32'(pin), 32'h0);
    tick();
    check("R3 pin follows clk high", 32'(pin), 32'h1);

    // R6: valid mode at ratio 3 with falling select ignored.
    wr(8'h3F, 8'h63);
    act = 1'b1; cnt = 0;
    for (int i = 0; i < 30; i++) begin tick(); cnt += int'(pin); end
    check("R6 one strobe per period", 32'(cnt), 32'd10);
    act = 1'b0; cnt = 0;
    for (int i = 0; i < 30; i++) begin tick(); cnt += int'(pin); end
    check("R6 none in blanking", 32'(cnt), 32'd0);
    for (int i = 0; i < 24; i++) begin act = i[1]; tick(); end

    // R7 / R8: power-down with wait of 3 periods at ratio 4.
    wr(8'h3F, 8'h04);
    wr(8'h3D, 8'h03);
    pd = 1'b1;
    repeat (5) tick();
    check("R7 ready low in pd", 32'(ready), 32'h0);
    check("R7 pin low in pd", 32'(pin), 32'h0);
    pd = 1'b0;
    for (int i = 0; i < 8; i++) begin tick(); check("R8 waiting", 32'(ready), 32'h0); end
    tick();
    check("R8 ready after 3 periods", 32'(ready), 32'h1);

    // R8: zero wait.
    wr(8'h3D, 8'h00);
    pd = 1'b1;
    repeat (3) tick();
    pd = 1'b0;
    tick();
    check("R8 zero wait", 32'(ready), 32'h1);

    // R6: no strobe while the wait runs.
    wr(8'h3D, 8'h04);
    wr(8'h3F, 8'h43);
    act = 1'b1;
    pd = 1'b1;
    repeat (2) tick();
    pd = 1'b0; cnt = 0;
    for (int i = 0; i < 9; i++) begin tick(); cnt += int'(pin); end
    check("R6 no strobe during wait", 32'(cnt), 32'd0);
    repeat (12) tick();

    // R1: other address ignored; R9: reserved bit.
    wr(8'h3E, 8'hFF);
    rd_chk("R1 count untouched", 8'h3D, 8'h04);
    rd_chk("R1 ctrl untouched", 8'h3F, 8'h43);
    rd_chk("R1 unmapped reads zero", 8'h3E, 8'h00);
    wr(8'h3F, 8'hC3);
    rd_chk("R9 reserved reads zero", 8'h3F, 8'h43);
    repeat (5) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule